// File: doc/BRIEF.md
# Horizontal Reference Loss Monitor

This block watches a horizontal sync reference and decides, line by line, whether each sync pulse arrived where it was expected. The expected line length is supplied as a count of system clocks (27 MHz clocks in the intended use). A rising edge of the sync input is taken as a valid line start when it lands inside a tolerance window of ±8 clocks centred on one line period after the previous valid line start. If no edge arrives in the window, the block keeps its expected timing running on its own, like a flywheel, and checks the next line one period later.

Missed lines are counted. The run-window setting gives the number of consecutive misses the block tolerates. A tolerated miss raises the lock-lost flag only until the next on-time pulse, and the block stays in genlock mode. One miss more than the run-window setting declares the reference lost and switches the mode output to freeze. In freeze, the block looks for the reference again. Any edge outside the window moves the expected timing onto that edge. Eight consecutive on-time pulses return the block to genlock and clear both flags together. The default setting of one tolerates a single miss and declares loss on the second consecutive miss.

Top module: `hsref_monitor`

## Requirements
- R1: While reset is held, and after its release until re-acquisition, freeze_mode, ref_lost and lock_lost are all 1.
- R2: A rising edge of hsync_in whose offset from the expected line start lies in the range line_period-8 to line_period+8 clocks, ends included, counts as on time. An edge at line_period-9 or line_period+9 does not.
- R3: In genlock with run_window=1, one missed line sets lock_lost to 1 while ref_lost and freeze_mode stay 0.
- R4: In genlock, run_window+1 consecutive missed lines set ref_lost, lock_lost and freeze_mode to 1. With run_window=0 a single miss does this, and with run_window=2 or 3 that many misses only set lock_lost.
- R5: One on-time pulse after tolerated misses clears lock_lost and restarts the count of consecutive misses.
- R6: A missed line moves the expected line start forward by exactly one line_period, so the next pulse is judged against the previous valid start plus two periods.
- R7: In genlock, an edge outside the window changes no output and does not move the expected timing.
- R8: In freeze, an edge outside the window becomes the new expected line start, and a miss or such an edge restarts the count of on-time pulses.
- R9: In freeze, 8 consecutive on-time pulses clear ref_lost, lock_lost and freeze_mode on the same cycle. 7 are not enough.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which counts the line period |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync reference, synchronous to clk, active on its rising edge |
| line_period | input | 16 | Expected line length in clocks |
| run_window | input | 2 | Number of consecutive missed lines tolerated before loss |
| lock_lost | output | 1 | 1 while lock is in doubt or lost |
| ref_lost | output | 1 | 1 while the reference is declared lost |
| freeze_mode | output | 1 | 1 = freeze, 0 = genlock |

## Verification
The assertions check on every cycle that a declared loss always comes with lock_lost. They check that entry to freeze follows a miss decision, that lock_lost falls only after an on-time pulse, and that the exit from freeze clears both flags together. They also check that edge detections and miss decisions never occur on two adjacent cycles. The window limits at ±8 and ±9, the flywheel timing after a miss, re-anchoring in freeze and the exact count of eight relock pulses involve whole line sequences. Only the bench scenarios can show these, by comparing against a line-level model.

// File: rtl/hsref_pkg.sv
// hsref_pkg: shared types and default sizes for the horizontal reference
// loss monitor. Assumes nothing beyond IEEE 1800-2017.
package hsref_pkg;

    // Operating mode of the monitor
    typedef enum logic {
        MODE_GENLOCK = 1'b0,
        MODE_FREEZE  = 1'b1
    } hsref_mode_t;

    localparam int HSREF_PERIOD_W = 16;  // width of the line period input
    localparam int HSREF_TOL      = 8;   // window half-width in clocks
    localparam int HSREF_RELOCK   = 8;   // on-time pulses needed to leave freeze
    localparam int HSREF_RW_W     = 2;   // width of the run-window setting

endpackage

// File: rtl/hsref_edge.sv
// hsref_edge: registers the sync input and flags each low-to-high
// transition for one cycle. Assumes hsync_in is already synchronous to clk.
// A level held high produces exactly one detection.
module hsref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    output logic rise
);

    logic hs_q;
    logic hs_qq;

    // Two-stage history of the sync level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q  <= 1'b0;
            hs_qq <= 1'b0;
        end else begin
            hs_q  <= hsync_in;
            hs_qq <= hs_q;
        end
    end

    // Rising transition seen between the two stages
    always_comb begin
        rise = hs_q & ~hs_qq;
    end

    AST_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2

endmodule

// File: rtl/hsref_window.sv
// hsref_window: counts clocks since the current expected line start and
// classifies each detected edge as on time (hit) or outside the window
// (stray). It raises miss when the window closes with no hit. A hit
// re-anchors the count. A miss moves the anchor one period on (flywheel).
// A stray re-anchors only when reanchor_en is high.
// Assumes line_period > 2*TOL and that the period is stable while in use.
module hsref_window #(
    parameter int PERIOD_W = 16,
    parameter int TOL      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic [PERIOD_W-1:0] period,
    input  logic                reanchor_en,
    output logic                hit,
    output logic                miss,
    output logic                stray
);

    localparam int CNT_W = PERIOD_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] p_ext;
    logic [CNT_W-1:0] win_lo;
    logic [CNT_W-1:0] win_hi;
    logic             in_win;

    // Window limits around the expected line start
    always_comb begin
        p_ext  = {1'b0, period};
        win_hi = p_ext + CNT_W'(TOL);
        win_lo = (p_ext > CNT_W'(TOL)) ? (p_ext - CNT_W'(TOL)) : '0;
        in_win = (cnt >= win_lo) && (cnt <= win_hi);
    end

    // Edge classification and miss decision at the closing of the window
    always_comb begin
        hit   = rise & in_win;
        stray = rise & ~in_win;
        miss  = ~hit & (cnt >= win_hi);
    end

    // Clock count since the anchor, with hit, re-anchor and flywheel steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hit || (stray && reanchor_en)) begin
            cnt <= CNT_W'(1);
        end else if (miss) begin
            cnt <= CNT_W'(TOL + 1);
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_MISS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !miss); // R6

    AST_HIT_NO_MISS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !miss); // R2

endmodule

// File: rtl/hsref_ctrl.sv
// hsref_ctrl: mode controller. In genlock it counts consecutive misses
// against the run-window setting and enters freeze when the count is
// exceeded. In freeze it counts consecutive hits and returns to genlock
// after RELOCK of them. Assumes hit, miss and stray come from one window
// unit, and that a hit and a miss never occur in the same cycle.
module hsref_ctrl
    import hsref_pkg::*;
#(
    parameter int RW_W   = 2,
    parameter int RELOCK = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic            miss,
    input  logic            stray,
    input  logic [RW_W-1:0] run_window,
    output logic            lock_lost,
    output logic            ref_lost,
    output logic            freeze_mode
);

    localparam int GOOD_W = $clog2(RELOCK + 1);

    hsref_mode_t     mode;
    logic            lock_lost_q;
    logic [RW_W-1:0] miss_cnt;
    logic [GOOD_W-1:0] good_cnt;

    // Mode, lock flag and the two run counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode        <= MODE_FREEZE;
            lock_lost_q <= 1'b1;
            miss_cnt    <= '0;
            good_cnt    <= '0;
        end else if (mode == MODE_GENLOCK) begin
            if (hit) begin
                miss_cnt    <= '0;
                lock_lost_q <= 1'b0;
            end else if (miss) begin
                lock_lost_q <= 1'b1;
                if (miss_cnt >= run_window) begin
                    mode     <= MODE_FREEZE;
                    miss_cnt <= '0;
                    good_cnt <= '0;
                end else begin
                    miss_cnt <= miss_cnt + 1'b1;
                end
            end
        end else begin
            if (hit) begin
                if (good_cnt == GOOD_W'(RELOCK - 1)) begin
                    mode        <= MODE_GENLOCK;
                    lock_lost_q <= 1'b0;
                    good_cnt    <= '0;
                    miss_cnt    <= '0;
                end else begin
                    good_cnt <= good_cnt + 1'b1;
                end
            end else if (miss || stray) begin
                good_cnt <= '0;
            end
        end
    end

    // Output decode
    always_comb begin
        lock_lost   = lock_lost_q;
        ref_lost    = (mode == MODE_FREEZE);
        freeze_mode = (mode == MODE_FREEZE);
    end

    AST_LOST_HAS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ref_lost |-> lock_lost); // R4

    AST_FREEZE_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_lost) |-> $past(miss)); // R4

    AST_LOCK_CLEAR_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_lost) |-> $past(hit)); // R5

    AST_RELOCK_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_lost) |-> ($fell(lock_lost) && $past(hit))); // R9

endmodule

// File: rtl/hsref_monitor.sv
// hsref_monitor: top of the horizontal reference loss monitor. It chains
// edge detection, window timing and mode control. Assumes hsync_in is
// synchronous to clk, line_period > 2*TOL and run_window changes only
// while the reference is steady.
module hsref_monitor
    import hsref_pkg::*;
#(
    parameter int PERIOD_W = HSREF_PERIOD_W,
    parameter int TOL      = HSREF_TOL,
    parameter int RELOCK   = HSREF_RELOCK,
    parameter int RW_W     = HSREF_RW_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsync_in,
    input  logic [PERIOD_W-1:0] line_period,
    input  logic [RW_W-1:0]     run_window,
    output logic                lock_lost,
    output logic                ref_lost,
    output logic                freeze_mode
);

    logic rise;
    logic hit;
    logic miss;
    logic stray;

    hsref_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync_in (hsync_in),
        .rise     (rise)
    );

    hsref_window #(
        .PERIOD_W (PERIOD_W),
        .TOL      (TOL)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .period      (line_period),
        .reanchor_en (freeze_mode),
        .hit         (hit),
        .miss        (miss),
        .stray       (stray)
    );

    hsref_ctrl #(
        .RW_W   (RW_W),
        .RELOCK (RELOCK)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .miss        (miss),
        .stray       (stray),
        .run_window  (run_window),
        .lock_lost   (lock_lost),
        .ref_lost    (ref_lost),
        .freeze_mode (freeze_mode)
    );

    AST_FREEZE_MATCHES_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_mode |-> (ref_lost && lock_lost)); // R4

endmodule

// File: tb/hsref_monitor_tb.sv
`timescale 1ns/1ps
module hsref_monitor_tb;

    localparam int P = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic [15:0] line_period = 16'(P);
    logic [1:0] run_window = 2'd1;
    logic       lock_lost;
    logic       ref_lost;
    logic       freeze_mode;

    int total = 0;
    int bad = 0;
    int now = 0;
    int anc = 0;
    bit m_lost = 1'b1;
    bit m_lock = 1'b1;
    int m_miss = 0;
    int m_good = 0;

    always #2 clk = ~clk;

    hsref_monitor u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_in    (hsync_in),
        .line_period (line_period),
        .run_window  (run_window),
        .lock_lost   (lock_lost),
        .ref_lost    (ref_lost),
        .freeze_mode (freeze_mode)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        now++;
    endtask

    task automatic wait_until(int t);
        while (now < t) tick();
    endtask

    task automatic pulse(int t);
        wait_until(t);
        hsync_in = 1'b1;
        repeat (4) tick();
        hsync_in = 1'b0;
    endtask

    // Line-level model: on-time pulse
    function automatic void model_hit();
        if (m_lost) begin
            m_good++;
            if (m_good == 8) begin
                m_lost = 1'b0; m_lock = 1'b0; m_good = 0; m_miss = 0;
            end
        end else begin
            m_miss = 0; m_lock = 1'b0;
        end
    endfunction

    // Line-level model: missed line
    function automatic void model_miss();
        if (m_lost) begin
            m_good = 0;
        end else if (m_miss >= int'(run_window)) begin
            m_lost = 1'b1; m_lock = 1'b1; m_good = 0; m_miss = 0;
        end else begin
            m_miss++; m_lock = 1'b1;
        end
    endfunction

    task automatic check(string rq);
        total++;
        if (lock_lost !== m_lock || ref_lost !== m_lost || freeze_mode !== m_lost) begin
            bad++;
            $display("FAIL %s: lock=%0b ref=%0b frz=%0b expected lock=%0b ref=%0b frz=%0b",
                     rq, lock_lost, ref_lost, freeze_mode, m_lock, m_lost, m_lost);
        end
    endtask

    // kind 0: on time with jitter j; 1: missing; 2: edge at offset P+j, |j|=9
    task automatic do_line(int kind, int j, string rq);
        if (kind == 0) begin
            pulse(anc + P + j);
            anc = anc + P + j;
            model_hit();
        end else if (kind == 1) begin
            anc = anc + P;
            model_miss();
        end else begin
            pulse(anc + P + j);
            if (m_lost) begin
                anc = anc + P + j;
                m_good = 0;
            end else begin
                anc = anc + P;
                model_miss();
            end
        end
        wait_until(anc + P / 2);
        check(rq);
    endtask

    // Edge well outside the window
    task automatic stray_edge(string rq);
        int t;
        t = anc + 60;
        pulse(t);
        if (m_lost) begin
            anc = t;
            m_good = 0;
        end
        wait_until(now + 4);
        check(rq);
    endtask

    task automatic relock();
        for (int i = 0; i < 8; i++) do_line(0, 0, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) tick();
        check("R1 in reset");
        rst_n = 1'b1;
        tick();
        check("R1 after reset");
        // first edge anchors the timing in freeze (R8)
        pulse(now + 5);
        anc = now - 4;
        wait_until(anc + 10);
        check("R8 first anchor");
        for (int i = 0; i < 7; i++) do_line(0, 0, "R9 seven pulses");
        do_line(0, 0, "R9 eighth pulse relock");
        // window edges
        do_line(0, -8, "R2 early edge -8");
        do_line(0, 8, "R2 late edge +8");
        do_line(0, 3, "R2 jitter");
        do_line(1, 0, "R3 single miss");
        do_line(0, 0, "R5 clear after miss");
        do_line(2, 9, "R2 late edge +9 is a miss");
        do_line(0, 0, "R6 flywheel after late edge");
        do_line(2, -9, "R2 early edge -9 is a miss");
        do_line(0, -8, "R6 flywheel after early edge");
        do_line(1, 0, "R6 miss");
        do_line(0, 8, "R6 pulse at two periods");
        stray_edge("R7 stray in genlock");
        do_line(0, 0, "R7 anchor unmoved");
        // loss with default setting
        do_line(1, 0, "R3 first miss");
        do_line(1, 0, "R4 second miss loses reference");
        stray_edge("R8 stray re-anchors in freeze");
        do_line(0, 0, "R8 count after re-anchor");
        do_line(0, 0, "R8 count");
        do_line(1, 0, "R8 miss restarts count");
        for (int i = 0; i < 7; i++) do_line(0, 0, "R9 seven again");
        stray_edge("R8 stray restarts count");
        relock();
        // run-window variants
        run_window = 2'd0;
        do_line(1, 0, "R4 run_window 0 single miss");
        relock();
        run_window = 2'd2;
        do_line(1, 0, "R4 run_window 2 miss 1");
        do_line(1, 0, "R4 run_window 2 miss 2");
        do_line(1, 0, "R4 run_window 2 miss 3");
        relock();
        run_window = 2'd3;
        do_line(1, 0, "R4 run_window 3 miss 1");
        do_line(1, 0, "R4 run_window 3 miss 2");
        do_line(0, 0, "R5 count restart");
        do_line(1, 0, "R4 run_window 3 miss 1b");
        do_line(1, 0, "R4 run_window 3 miss 2b");
        do_line(1, 0, "R4 run_window 3 miss 3b");
        do_line(0, 0, "R5 clear after three");
        run_window = 2'd1;
        // random line mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 72) do_line(0, int'($urandom % 17) - 8, "R2 R5 R9 random on time");
            else if (r < 85) do_line(1, 0, "R3 R4 random miss");
            else if (r < 92) do_line(2, ($urandom % 2) != 0 ? 9 : -9, "R2 R8 random off edge");
            else stray_edge("R7 R8 random stray");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule